// File: doc/BRIEF.md
# Busy Aggregation and Masking Unit

This block gathers every busy indication a timing module can see (its own internal busy, two front-panel external busy inputs, a front-panel read-out busy input, a vector of per-slot backplane read-out busies, and two software-forced busy bits) and merges them into the module's busy outputs. Each source reaches an output only through its own enable bit, so the surrounding control logic can choose which sources hold off triggers.

Several separately enabled trees are built in parallel. The general busy output uses enables for the internal, external and read-out terms. The trigger busy output is the same tree with the internal term always on. The crate busy output ORs the unmasked backplane slots with the gated front-panel read-out busy and a software bit. It is forced on in standalone mode and held off while the module is not OK. A 16-bit status word carries the intermediate and final results. All outputs come from one register stage.

Top module: `busy_merge_unit`

## Requirements
- R1: The external busy is the OR of `nim_ext_busy_i` and `ecl_ext_busy_i` and is reported in status bit 0.
- R2: `ext_busy_masked_o` is the external busy ANDed with `en_ext_i`, also reported in status bit 1.
- R3: `busy_o` is the OR of internal busy AND `en_int_i`, external busy AND `en_ext_i`, `sw_busy_i`, and `fp_rod_busy_i` AND `en_rod_i`, and is reported in status bit 3.
- R4: `trig_busy_o` equals the R3 tree except that the internal busy term needs no enable.
- R5: The crate busy includes the OR over slots of `slot_busy_i[i]` AND NOT `slot_mask_i[i]`, so a mask bit of 1 excludes that slot.
- R6: The crate busy also includes `fp_rod_busy_i` AND `en_rod_i`, and `sw_crate_busy_i`. It drives `crate_busy_o` and `crate_led_o` identically and is reported in status bit 7.
- R7: While `module_ok_i` is 0, the crate busy is 0 unless standalone mode is set. The internal busy is also removed from `busy_o`, `trig_busy_o` and status bit 2, which otherwise carries the internal busy.
- R8: `standalone_i` forces the crate busy to 1 regardless of `module_ok_i`, and is reported in status bit 11.
- R9: All outputs are registered. A change sampled at one rising clock edge appears just after that edge. During reset all outputs are 0.
- R10: Status bits 4-6, 8-10 and 12-15 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_busy_i | input | 1 | Internal busy of the module |
| nim_ext_busy_i | input | 1 | External busy, NIM front-panel path |
| ecl_ext_busy_i | input | 1 | External busy, ECL front-panel path |
| fp_rod_busy_i | input | 1 | Front-panel read-out busy |
| slot_busy_i | input | N_SLOTS | Per-slot backplane read-out busies |
| slot_mask_i | input | N_SLOTS | Per-slot mask, 1 excludes the slot |
| sw_busy_i | input | 1 | Software-forced general busy |
| sw_crate_busy_i | input | 1 | Software-forced crate busy |
| en_int_i | input | 1 | Enable of internal busy into busy_o |
| en_ext_i | input | 1 | Enable of external busy |
| en_rod_i | input | 1 | Enable of front-panel read-out busy |
| standalone_i | input | 1 | Standalone mode flag |
| module_ok_i | input | 1 | Module OK flag |
| busy_o | output | 1 | General busy out |
| trig_busy_o | output | 1 | Trigger busy, internal term always enabled |
| ext_busy_masked_o | output | 1 | Enabled external busy |
| crate_busy_o | output | 1 | Crate busy to the backplane |
| crate_led_o | output | 1 | Crate busy to the indicator |
| status_o | output | 16 | Status word |

## Verification
The bench drives each source alone, with its enable both set and cleared. This separates the busy_o and trig_busy_o trees and shows that each enable affects only its own term. Slot patterns pair a busy slot with its own mask bit and with other slots' mask bits, which shows that masking works per slot and not as a whole. Combinations of module-OK and standalone with every crate source active show the suppression and its priority. An all-ones pattern shows that the unused status bits stay at 0.

// File: rtl/busy_merge_pkg.sv
package busy_merge_pkg;
  localparam int STAT_W   = 16;
  localparam int ST_EXT   = 0;
  localparam int ST_EXT_M = 1;
  localparam int ST_INT   = 2;
  localparam int ST_BUSY  = 3;
  localparam int ST_CRATE = 7;
  localparam int ST_SA    = 11;

  typedef struct packed {
    logic              busy;
    logic              trig;
    logic              ext_m;
    logic              crate;
    logic [STAT_W-1:0] status;
  } busy_bundle_t;
endpackage

// File: rtl/busy_slot_reduce.sv
module busy_slot_reduce #(
  parameter int N_SLOTS = 16
) (
  input  logic [N_SLOTS-1:0] busy_i,
  input  logic [N_SLOTS-1:0] mask_i,
  output logic               any_o
);
  logic [N_SLOTS-1:0] hit;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    assign hit[i] = busy_i[i] & ~mask_i[i];
  end

  assign any_o = |hit;
endmodule

// File: rtl/busy_out_stage.sv
module busy_out_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/busy_merge_unit.sv
module busy_merge_unit
  import busy_merge_pkg::*;
#(
  parameter int N_SLOTS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               int_busy_i,
  input  logic               nim_ext_busy_i,
  input  logic               ecl_ext_busy_i,
  input  logic               fp_rod_busy_i,
  input  logic [N_SLOTS-1:0] slot_busy_i,
  input  logic [N_SLOTS-1:0] slot_mask_i,
  input  logic               sw_busy_i,
  input  logic               sw_crate_busy_i,
  input  logic               en_int_i,
  input  logic               en_ext_i,
  input  logic               en_rod_i,
  input  logic               standalone_i,
  input  logic               module_ok_i,
  output logic               busy_o,
  output logic               trig_busy_o,
  output logic               ext_busy_masked_o,
  output logic               crate_busy_o,
  output logic               crate_led_o,
  output logic [STAT_W-1:0]  status_o
);
  localparam int BW = $bits(busy_bundle_t);

  logic         ext_any, ext_en, int_ok, rod_en, slot_any;
  logic         common_terms, crate_d;
  busy_bundle_t nxt, cur;

  busy_slot_reduce #(.N_SLOTS(N_SLOTS)) u_slots (
    .busy_i (slot_busy_i),
    .mask_i (slot_mask_i),
    .any_o  (slot_any)
  );

  always_comb begin
    ext_any      = nim_ext_busy_i | ecl_ext_busy_i;
    ext_en       = ext_any & en_ext_i;
    int_ok       = int_busy_i & module_ok_i;   // not-OK hides internal busy
    rod_en       = fp_rod_busy_i & en_rod_i;
    common_terms = ext_en | sw_busy_i | rod_en;
    // standalone wins over not-OK suppression
    crate_d      = standalone_i | (module_ok_i & (slot_any | rod_en | sw_crate_busy_i));

    nxt                  = '0;
    nxt.busy             = (int_ok & en_int_i) | common_terms;
    nxt.trig             = int_ok | common_terms;
    nxt.ext_m            = ext_en;
    nxt.crate            = crate_d;
    nxt.status[ST_EXT]   = ext_any;
    nxt.status[ST_EXT_M] = ext_en;
    nxt.status[ST_INT]   = int_ok;
    nxt.status[ST_BUSY]  = nxt.busy;
    nxt.status[ST_CRATE] = crate_d;
    nxt.status[ST_SA]    = standalone_i;
  end

  busy_out_stage #(.W(BW)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt),
    .q_o    (cur)
  );

  assign busy_o            = cur.busy;
  assign trig_busy_o       = cur.trig;
  assign ext_busy_masked_o = cur.ext_m;
  assign crate_busy_o      = cur.crate;
  assign crate_led_o       = cur.crate;
  assign status_o          = cur.status;

  // R7
  not_ok_crate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!module_ok_i && !standalone_i) |=> !crate_busy_o);

  // R8
  standalone_crate_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standalone_i |=> (crate_busy_o && status_o[ST_SA]));

  // R4
  trig_covers_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> trig_busy_o);

  // R2
  ext_masked_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_busy_masked_o |-> (busy_o && status_o[ST_EXT]));

  // R7
  not_ok_int_hidden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !module_ok_i |=> !status_o[ST_INT]);

  // R5
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&slot_mask_i && !standalone_i && !sw_crate_busy_i && !(fp_rod_busy_i && en_rod_i))
      |=> !crate_busy_o);
endmodule

// File: tb/busy_merge_unit_tb.sv
`timescale 1ns/1ps
module busy_merge_unit_tb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_b = 0, nim_b = 0, ecl_b = 0, fp_b = 0, sw_b = 0, swc_b = 0;
  logic en_int = 0, en_ext = 0, en_rod = 0, sa = 0, ok = 1;
  logic [N-1:0] sb = '0, sm = '0;

  logic busy, trig, extm, crate, led;
  logic [15:0] status;

  int checks = 0, errors = 0;
  logic [20:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  busy_merge_unit #(.N_SLOTS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .int_busy_i(int_b), .nim_ext_busy_i(nim_b),
    .ecl_ext_busy_i(ecl_b), .fp_rod_busy_i(fp_b), .slot_busy_i(sb), .slot_mask_i(sm),
    .sw_busy_i(sw_b), .sw_crate_busy_i(swc_b), .en_int_i(en_int), .en_ext_i(en_ext),
    .en_rod_i(en_rod), .standalone_i(sa), .module_ok_i(ok), .busy_o(busy),
    .trig_busy_o(trig), .ext_busy_masked_o(extm), .crate_busy_o(crate),
    .crate_led_o(led), .status_o(status)
  );

  wire [20:0] dut_vec = {busy, trig, extm, crate, led, status};

  function automatic logic [20:0] model();
    logic e, ie, rterm, b, t, c;
    logic [15:0] st;
    e     = nim_b | ecl_b;
    ie    = int_b & ok;
    rterm = fp_b & en_rod;
    b     = (ie & en_int) | (e & en_ext) | sw_b | rterm;
    t     = ie | (e & en_ext) | sw_b | rterm;
    c     = sa | (ok & ((|(sb & ~sm)) | rterm | swc_b));
    st     = '0;
    st[0]  = e;
    st[1]  = e & en_ext;
    st[2]  = ie;
    st[3]  = b;
    st[7]  = c;
    st[11] = sa;
    return {b, t, e & en_ext, c, c, st};
  endfunction

  task automatic step(input string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic clear_in();
    int_b = 0; nim_b = 0; ecl_b = 0; fp_b = 0; sw_b = 0; swc_b = 0;
    en_int = 0; en_ext = 0; en_rod = 0; sa = 0; ok = 1; sb = '0; sm = '0;
  endtask

  // monitor: one expected item per cycle, compared just after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      logic [20:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (dut_vec !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, dut_vec, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int_b = 1; sa = 1; sw_b = 1; nim_b = 1; en_int = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (dut_vec !== 21'h0) begin
      errors++;
      $display("FAIL R9 reset: actual %h expected %h", dut_vec, 21'h0);
    end
    clear_in();
    rst_n = 1'b1;
    @(negedge clk);

    step("R9 idle");
    nim_b = 1;                      step("R1 nim only, ext disabled");
    nim_b = 0; ecl_b = 1;           step("R1 ecl only");
    en_ext = 1;                     step("R2 ecl enabled");
    ecl_b = 0; nim_b = 1;           step("R2 nim enabled");
    clear_in(); en_ext = 1;         step("R2 enable without source");
    clear_in(); int_b = 1;          step("R4 internal, no enable");
    en_int = 1;                     step("R3 internal enabled");
    clear_in(); sw_b = 1;           step("R3 software busy");
    clear_in(); fp_b = 1;           step("R6 fp rod disabled");
    en_rod = 1;                     step("R3 fp rod enabled");
    clear_in(); sb[3] = 1; sm[3] = 1; step("R5 own mask excludes");
    sm = 16'hFFF7;                  step("R5 other masks keep");
    sb = 16'h8000; sm = 16'h7FFF;   step("R5 top slot");
    sb = 16'h0001; sm = 16'h0000;   step("R5 bottom slot");
    clear_in(); swc_b = 1;          step("R6 software crate busy");
    clear_in(); ok = 0; int_b = 1; en_int = 1; sb = '1; swc_b = 1;
    fp_b = 1; en_rod = 1;           step("R7 not ok suppresses");
    sw_b = 1;                       step("R7 not ok software busy");
    clear_in(); ok = 0; sa = 1;
    checks++;
    if (crate !== 1'b0) begin
      errors++;
      $display("FAIL R9 latency: actual %b expected %b", crate, 1'b0);
    end
    step("R8 standalone over not ok");
    ok = 1;                         step("R8 standalone ok");
    clear_in(); sa = 0; ok = 1;     step("R8 standalone release");
    int_b = 1; nim_b = 1; ecl_b = 1; fp_b = 1; sw_b = 1; swc_b = 1;
    en_int = 1; en_ext = 1; en_rod = 1; sa = 1; sb = '1;
                                    step("R10 all ones");
    clear_in();                     step("R9 back to idle");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule